// File: doc/BRIEF.md
# Integer ALU with Condition Flags

A single-cycle 64-bit integer execution unit for a pipelined core. Each cycle in which `issue` is high it takes already decoded control fields, up to three register read values and an immediate. It picks the two operands, may complement the first, adds a selectable carry-in, and computes a sum, a bitwise AND, a bitwise OR or the low half of a product. The result and its destination index appear in the same cycle with a write enable. A carry flag and a three-bit sign/zero condition field are kept in registers and change on the clock edge that ends the cycle.

The register file and the instruction decoder are outside the block. Their outputs arrive on the ports as valid/data pairs and control bits. An opcode outside the supported set raises `illegalOp` for that cycle, and neither the register write nor the flags take effect.

Top module: `int_exec_unit`

## Requirements
- R1: Operand A is `rdAData` when `rdAValid` is high, else `rdCData` when `rdCValid` is high, else zero.
- R2: Operand B is `immData` when `immValid` is high (whatever `rdBValid` is), else `rdBData` when `rdBValid` is high, else zero.
- R3: When `invA` is high, operand A is replaced by its 64-bit bitwise complement before the operation.
- R4: `carrySel` picks the carry-in: 2'b00 zero, 2'b01 one, 2'b10 the stored carry flag, 2'b11 zero. The carry-in is added only by the add operation.
- R5: `opCode` 3'b000 gives A+B+carry-in, 3'b001 gives A AND B, 3'b010 gives A OR B, 3'b011 gives the low 64 bits of A×B. `wrData` is the low 64 bits of the result in the same cycle.
- R6: On an issued legal operation with `carryOutEn` high, `carryFlag` takes bit 64 of the unwrapped result on the next clock edge (the sum's carry; 0 for AND and OR; bit 64 of the full product for the multiply). Otherwise it holds.
- R7: On an issued legal operation with `recordEn` high, `condField` becomes 3'b001 for a zero 64-bit result, 3'b100 when result bit 63 is set, and 3'b010 otherwise, on the next clock edge. Otherwise it holds.
- R8: `wrEn` is high only in a cycle with `issue`, `wrValid` and a legal opcode. `wrAddr` repeats `wrIdx`.
- R9: An issued opcode 3'b100 to 3'b111 drives `illegalOp` high in that cycle, keeps `wrEn` low, and leaves both flags unchanged.
- R10: While `rstN` is low, `carryFlag` and `condField` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation select |
| invA | input | 1 | Complement operand A |
| carrySel | input | 2 | Carry-in source |
| carryOutEn | input | 1 | Capture the carry flag |
| recordEn | input | 1 | Update the condition field |
| rdAValid | input | 1 | First read value is valid |
| rdAData | input | 64 | First read value |
| rdBValid | input | 1 | Second read value is valid |
| rdBData | input | 64 | Second read value |
| rdCValid | input | 1 | Third read value is valid |
| rdCData | input | 64 | Third read value |
| immValid | input | 1 | Immediate is valid |
| immData | input | 64 | Immediate value |
| wrValid | input | 1 | Operation has a destination register |
| wrIdx | input | 5 | Destination register index |
| wrEn | output | 1 | Register write enable |
| wrAddr | output | 5 | Register write index |
| wrData | output | 64 | Register write value |
| carryFlag | output | 1 | Stored carry flag |
| condField | output | 3 | Stored condition field |
| illegalOp | output | 1 | Unsupported opcode this cycle |

## Verification
Directed patterns turn the read-valid bits on and off one at a time with distinct values on each port, so a wrong operand priority gives a different sum. All-zero operands with inversion and a carry-in of one produce a zero result with a carry out, which exercises the complement, the carry capture and the zero condition code together. The stored-flag carry source is then used straight after a capture. A long run of mixed valid bits, opcodes and data, illegal codes included, is compared each cycle against a behavioural model that uses 128-bit arithmetic, which separates bit-64 carries of the sum and the product from the truncated result.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int OP_W   = 3;
  localparam int CIN_W  = 2;
  localparam int COND_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_AND   = 3'd1,
    OP_OR    = 3'd2,
    OP_MULLO = 3'd3
  } aluOpE;

  typedef enum logic [CIN_W-1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSrcE;

  localparam logic [COND_W-1:0] COND_ZERO = 3'b001;
  localparam logic [COND_W-1:0] COND_NEG  = 3'b100;
  localparam logic [COND_W-1:0] COND_POS  = 3'b010;

  // strobes from control to datapath
  typedef struct packed {
    logic   selAdd;
    logic   selAnd;
    logic   selOr;
    logic   selMul;
    cinSrcE cinSrc;
    logic   wrStb;
    logic   carryStb;
    logic   condStb;
  } aluStbT;
endpackage

// File: rtl/int_exec_ctrl.sv
module int_exec_ctrl
  import int_exec_pkg::*;
(
  input  logic            issue,
  input  logic [OP_W-1:0] opCode,
  input  logic [CIN_W-1:0] carrySel,
  input  logic            carryOutEn,
  input  logic            recordEn,
  input  logic            wrValid,
  output aluStbT          stb,
  output logic            illegalOp
);
  logic legal;

  always_comb begin
    stb    = '0;
    legal  = 1'b1;
    unique case (opCode)
      OP_ADD:   stb.selAdd = 1'b1;
      OP_AND:   stb.selAnd = 1'b1;
      OP_OR:    stb.selOr  = 1'b1;
      OP_MULLO: stb.selMul = 1'b1;
      default:  legal      = 1'b0;
    endcase
    unique case (carrySel)
      2'd1:    stb.cinSrc = CIN_ONE;
      2'd2:    stb.cinSrc = CIN_FLAG;
      default: stb.cinSrc = CIN_ZERO;
    endcase
    stb.wrStb    = issue && legal && wrValid;
    stb.carryStb = issue && legal && carryOutEn;
    stb.condStb  = issue && legal && recordEn;
  end

  assign illegalOp = issue && !legal;
endmodule

// File: rtl/int_exec_dpath.sv
module int_exec_dpath
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStbT            stb,
  input  logic              invA,
  input  logic              rdAValid,
  input  logic [DATA_W-1:0] rdAData,
  input  logic              rdBValid,
  input  logic [DATA_W-1:0] rdBData,
  input  logic              rdCValid,
  input  logic [DATA_W-1:0] rdCData,
  input  logic              immValid,
  input  logic [DATA_W-1:0] immData,
  output logic [DATA_W-1:0] result,
  output logic              carryFlag,
  output logic [COND_W-1:0] condField
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] srcA, opA, opB;
  logic              cinBit;
  logic [EXT_W-1:0]  sumExt, andExt, orExt, mulExt, resExt;
  logic [COND_W-1:0] condNext;
  logic              carryQ;
  logic [COND_W-1:0] condQ;

  // operand A: first port, then third port, then zero
  always_comb begin
    if (rdAValid)      srcA = rdAData;
    else if (rdCValid) srcA = rdCData;
    else               srcA = '0;
  end
  assign opA = invA ? ~srcA : srcA;

  // operand B: immediate wins over the second port
  always_comb begin
    if (immValid)      opB = immData;
    else if (rdBValid) opB = rdBData;
    else               opB = '0;
  end

  always_comb begin
    unique case (stb.cinSrc)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = carryQ;
      default:  cinBit = 1'b0;
    endcase
  end

  assign sumExt = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, cinBit};
  assign andExt = {1'b0, opA & opB};
  assign orExt  = {1'b0, opA | opB};
  // product truncated to DATA_W+1 bits: its top bit equals bit DATA_W of the full product
  assign mulExt = {1'b0, opA} * {1'b0, opB};

  assign resExt = ({EXT_W{stb.selAdd}} & sumExt)
                | ({EXT_W{stb.selAnd}} & andExt)
                | ({EXT_W{stb.selOr}}  & orExt)
                | ({EXT_W{stb.selMul}} & mulExt);

  assign result = resExt[DATA_W-1:0];

  always_comb begin
    if (result == '0)          condNext = COND_ZERO;
    else if (result[DATA_W-1]) condNext = COND_NEG;
    else                       condNext = COND_POS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      condQ  <= '0;
    end else begin
      if (stb.carryStb) carryQ <= resExt[DATA_W];
      if (stb.condStb)  condQ  <= condNext;
    end
  end

  assign carryFlag = carryQ;
  assign condField = condQ;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [OP_W-1:0]   opCode,
  input  logic              invA,
  input  logic [CIN_W-1:0]  carrySel,
  input  logic              carryOutEn,
  input  logic              recordEn,
  input  logic              rdAValid,
  input  logic [DATA_W-1:0] rdAData,
  input  logic              rdBValid,
  input  logic [DATA_W-1:0] rdBData,
  input  logic              rdCValid,
  input  logic [DATA_W-1:0] rdCData,
  input  logic              immValid,
  input  logic [DATA_W-1:0] immData,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              carryFlag,
  output logic [COND_W-1:0] condField,
  output logic              illegalOp
);
  aluStbT stb;

  int_exec_ctrl uCtrl (
    .issue      (issue),
    .opCode     (opCode),
    .carrySel   (carrySel),
    .carryOutEn (carryOutEn),
    .recordEn   (recordEn),
    .wrValid    (wrValid),
    .stb        (stb),
    .illegalOp  (illegalOp)
  );

  int_exec_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .invA      (invA),
    .rdAValid  (rdAValid),
    .rdAData   (rdAData),
    .rdBValid  (rdBValid),
    .rdBData   (rdBData),
    .rdCValid  (rdCValid),
    .rdCData   (rdCData),
    .immValid  (immValid),
    .immData   (immData),
    .result    (wrData),
    .carryFlag (carryFlag),
    .condField (condField)
  );

  assign wrEn   = stb.wrStb;
  assign wrAddr = wrIdx;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              issue,
  input logic              carryOutEn,
  input logic              recordEn,
  input logic              wrValid,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [IDX_W-1:0]  wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              carryFlag,
  input logic [COND_W-1:0] condField,
  input logic              illegalOp
);
  // R9: illegal opcode never writes
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !wrEn);
  // R9: illegal opcode leaves flags alone
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> ($stable(carryFlag) && $stable(condField)));
  // R6: flag holds without a capture request
  a_r6_carry_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(issue && carryOutEn) |=> $stable(carryFlag));
  // R7: condition field holds without a record request
  a_r7_cond_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(issue && recordEn) |=> $stable(condField));
  // R7: at most one condition bit
  a_r7_cond_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(condField));
  // R8: write needs an issued operation with a destination
  a_r8_write_gate: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (issue && wrValid));
  // R8: write index follows the request
  a_r8_addr_follow: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrAddr == wrIdx));
  // R10: flags are clear when reset is released
  a_r10_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (!carryFlag && condField == '0));

  logic unusedData;
  assign unusedData = ^wrData;
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uChk (.*);

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issue, invA, carryOutEn, recordEn;
  logic [2:0]  opCode;
  logic [1:0]  carrySel;
  logic        rdAValid, rdBValid, rdCValid, immValid, wrValid;
  logic [63:0] rdAData, rdBData, rdCData, immData;
  logic [4:0]  wrIdx;
  logic        wrEn, carryFlag, illegalOp;
  logic [4:0]  wrAddr;
  logic [63:0] wrData;
  logic [2:0]  condField;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  logic       mCarry;
  logic [2:0] mCond;

  always #(CLK_P/2) clk = ~clk;

  int_exec_unit u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    issue = 0; opCode = 0; invA = 0; carrySel = 0; carryOutEn = 0; recordEn = 0;
    rdAValid = 0; rdBValid = 0; rdCValid = 0; immValid = 0; wrValid = 0;
    rdAData = 0; rdBData = 0; rdCData = 0; immData = 0; wrIdx = 0;
  endtask

  // behavioural reference in 128-bit arithmetic
  task automatic model(output logic [127:0] full, output bit legal);
    logic [127:0] a, b, cin;
    a = rdAValid ? {64'd0, rdAData} : rdCValid ? {64'd0, rdCData} : 128'd0;
    if (invA) a = {64'd0, ~a[63:0]};
    b = immValid ? {64'd0, immData} : rdBValid ? {64'd0, rdBData} : 128'd0;
    cin = (carrySel == 2'd1) ? 128'd1 : (carrySel == 2'd2) ? {127'd0, mCarry} : 128'd0;
    legal = 1;
    case (opCode)
      3'd0: full = a + b + cin;
      3'd1: full = a & b;
      3'd2: full = a | b;
      3'd3: full = a * b;
      default: begin full = 0; legal = 0; end
    endcase
  endtask

  // inputs are set after a falling edge; check, clock, update model
  task automatic run(string tag);
    logic [127:0] full;
    bit legal;
    logic [2:0] c;
    #1;
    model(full, legal);
    check("R10/R6 carryFlag", {63'd0, carryFlag}, {63'd0, mCarry});
    check("R10/R7 condField", {61'd0, condField}, {61'd0, mCond});
    check("R8 wrEn", {63'd0, wrEn}, {63'd0, issue && legal && wrValid});
    check("R9 illegalOp", {63'd0, illegalOp}, {63'd0, issue && !legal});
    if (issue && legal) begin
      check(tag, wrData, full[63:0]);
      check("R8 wrAddr", {59'd0, wrAddr}, {59'd0, wrIdx});
    end
    @(posedge clk);
    if (rstN && issue && legal) begin
      if (carryOutEn) mCarry = full[64];
      if (recordEn) begin
        c = (full[63:0] == 0) ? 3'b001 : full[63] ? 3'b100 : 3'b010;
        mCond = c;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    mCarry = 0; mCond = 0;
    repeat (3) @(negedge clk);
    // R10: cleared under reset
    check("R10 carry at reset", {63'd0, carryFlag}, 64'd0);
    check("R10 cond at reset", {61'd0, condField}, 64'd0);
    rstN = 1;
    @(negedge clk);

    // R1: operand A priority
    issue = 1; wrValid = 1; wrIdx = 5'd7; opCode = 3'd0;
    rdAValid = 1; rdAData = 64'd5; rdCValid = 1; rdCData = 64'd9;
    rdBValid = 1; rdBData = 64'd3;
    run("R1 A from first port");
    rdAValid = 0; run("R1 A from third port");
    rdCValid = 0; run("R1 A zero");

    // R2: immediate beats second port
    rdAValid = 1; immValid = 1; immData = 64'd100; run("R2 imm over B");
    immValid = 0; rdBValid = 0; run("R2 B zero");

    // R3 + R6 + R7: ~0 + 0 + 1 wraps to zero with carry
    rdAValid = 1; rdAData = 0; rdBValid = 1; rdBData = 0;
    invA = 1; carrySel = 2'd1; carryOutEn = 1; recordEn = 1;
    run("R3 inverted A");
    run("R6 carry captured");
    // R4: stored flag as carry-in, then 2'b11 as zero
    invA = 0; carryOutEn = 0; rdAData = 64'd1; rdBData = 64'd1;
    carrySel = 2'd2; run("R4 carry from flag");
    carrySel = 2'd3; run("R4 code 3 is zero");
    carrySel = 2'd0; run("R4 zero carry");

    // R5 / R7 on the other operations
    rdAData = 64'hF0F0_0000_FFFF_1234; rdBData = 64'h8FF0_00FF_0F0F_4321;
    opCode = 3'd1; run("R5 AND"); run("R7 negative result");
    opCode = 3'd2; run("R5 OR");
    rdAData = 64'hFFFF_FFFF_FFFF_FFFF; rdBData = 64'd2; carryOutEn = 1;
    opCode = 3'd3; run("R5 MUL low half"); run("R6 product bit 64");
    rdAData = 64'd3; rdBData = 64'd4; run("R7 positive result");

    // R8: no destination, then no issue
    wrValid = 0; run("R8 no destination");
    wrValid = 1; issue = 0; rdAData = 0; run("R8 no issue");

    // R9: illegal opcodes with every request set
    issue = 1; rdAData = 64'hFFFF_FFFF_FFFF_FFFF; rdBData = 64'd7;
    carryOutEn = 1; recordEn = 1;
    for (int k = 4; k < 8; k++) begin
      opCode = 3'(k); run("R9 illegal opcode");
    end

    // mixed patterns
    for (int i = 0; i < 3000; i++) begin
      issue = ($urandom_range(0, 7) != 0);
      opCode = 3'($urandom_range(0, 4) == 4 ? $urandom_range(4, 7) : $urandom_range(0, 3));
      invA = 1'($urandom); carrySel = 2'($urandom);
      carryOutEn = 1'($urandom); recordEn = 1'($urandom); wrValid = 1'($urandom);
      rdAValid = 1'($urandom); rdBValid = 1'($urandom);
      rdCValid = 1'($urandom); immValid = 1'($urandom);
      rdAData = {$urandom, $urandom}; rdBData = {$urandom, $urandom};
      rdCData = {$urandom, $urandom}; immData = {$urandom, $urandom};
      if ($urandom_range(0, 9) == 0) rdBData = 64'd0;
      wrIdx = 5'($urandom);
      run("R5 mixed result");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule